// File: doc/BRIEF.md
# Single-Cycle 4-bit Processor Core

This block is a minimal single-cycle processor. Every rising clock edge fetches one 16-bit instruction and executes it completely. The instruction comes from a small instruction store addressed by the program counter. Execution reads up to two registers, runs the ALU and writes the result back. It also selects the next program counter, either the sequential address or a branch target. The register file holds four data registers, each 4 bits wide. A combinational decoder turns the 4-bit opcode into the ALU operation, the operand-B source, the register write strobe and the branch condition.

Program loading goes through a separate write port into the instruction store. That port also works while the synchronous reset is held. The usual sequence is to hold reset, write the program and then release reset. The first instruction executes on the first rising edge after release. Debug outputs show all register contents and the live ALU result of the instruction being executed.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter and every register are cleared to 0. After reset the first instruction executed is the one at address 0.
- R2: Instructions are decoded as follows: opcode in bits 15:12, destination or test register in bits 11:8, first source in bits 7:4, and second source or unsigned immediate in bits 3:0.
- R3: Opcode 0000 writes Rs1+Rs2, 0001 writes Rs1-Rs2, 0010 writes Rs1 AND Rs2 and 0011 writes Rs1 OR Rs2 to Rd. Arithmetic wraps modulo 16.
- R4: Opcode 0100 writes 1 to Rd when Rs1 is less than Rs2 as unsigned values, and 0 otherwise.
- R5: Opcode 0110 writes the immediate to Rd. Opcode 0111 writes Rs1 plus the immediate to Rd, modulo 16. Operand B is the immediate for these two opcodes and the Rs2 register value for the R-type opcodes.
- R6: A register field selects a register through its low 2 bits only. The upper 2 bits have no effect.
- R7: Opcode 1000 branches when the register named in bits 11:8 is zero. Opcode 1001 branches when that register is nonzero. A taken branch sets the PC to the current PC plus the immediate, modulo 16. Neither opcode writes a register.
- R8: When no branch is taken, the PC advances by 1 each cycle and wraps from 15 to 0.
- R9: Opcodes 0101 and 1010 to 1111 write no register and advance the PC by 1.
- R10: `dbg_alu` shows, during a cycle, the value that the current register-writing instruction stores on the next edge. `dbg_regs` bits [4i+3:4i] show register i.
- R11: When `imem_we` is high at a rising edge, `imem_wdata` is written to instruction address `imem_waddr`. This also works while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_we | input | 1 | Instruction store write strobe |
| imem_waddr | input | 4 | Instruction store write address |
| imem_wdata | input | 16 | Instruction word to store |
| dbg_regs | output | 16 | All register contents, register i in bits [4i+3:4i] |
| dbg_alu | output | 4 | Current ALU result |

## Verification
The bench builds the core with its default parameters: 4-bit data, a 4-bit program counter with a 16-word instruction store, and four registers. With these values the register and PC wrap points lie only a few additions away. Short programs therefore reach carry-out, borrow, PC wrap-around from 15 to 0 and zero-offset self-loops. The 4-bit fields leave upper index bits spare, so random words naturally exercise register aliasing and the undefined opcodes. Directed programs cover the arithmetic sequence, taken and untaken branches in both polarities, and aliased register fields.

// File: rtl/sc_pkg.sv
package sc_pkg;
   localparam int INSTR_W = 16;
   localparam int FIELD_W = 4;

   localparam logic [FIELD_W-1:0] OPC_ADD  = 4'h0;
   localparam logic [FIELD_W-1:0] OPC_SUB  = 4'h1;
   localparam logic [FIELD_W-1:0] OPC_AND  = 4'h2;
   localparam logic [FIELD_W-1:0] OPC_OR   = 4'h3;
   localparam logic [FIELD_W-1:0] OPC_SLT  = 4'h4;
   localparam logic [FIELD_W-1:0] OPC_LDI  = 4'h6;
   localparam logic [FIELD_W-1:0] OPC_ADI  = 4'h7;
   localparam logic [FIELD_W-1:0] OPC_BEZ  = 4'h8;
   localparam logic [FIELD_W-1:0] OPC_BNZ  = 4'h9;

   typedef enum logic [2:0] {
      ALU_ADD,
      ALU_SUB,
      ALU_AND,
      ALU_OR,
      ALU_SLT,
      ALU_PASSB
   } alu_op_e;

   typedef struct packed {
      alu_op_e alu_op;
      logic    use_imm;
      logic    reg_wr;
      logic    branch;
      logic    br_on_zero;
      logic    test_rd;
   } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
   import sc_pkg::*;
(
   input  logic [FIELD_W-1:0] opcode,
   output ctrl_t              ctrl
);
   always_comb begin
      ctrl = '{alu_op: ALU_ADD, use_imm: 1'b0, reg_wr: 1'b0,
               branch: 1'b0, br_on_zero: 1'b0, test_rd: 1'b0};
      case (opcode)
         OPC_ADD: begin ctrl.alu_op = ALU_ADD; ctrl.reg_wr = 1'b1; end
         OPC_SUB: begin ctrl.alu_op = ALU_SUB; ctrl.reg_wr = 1'b1; end
         OPC_AND: begin ctrl.alu_op = ALU_AND; ctrl.reg_wr = 1'b1; end
         OPC_OR:  begin ctrl.alu_op = ALU_OR;  ctrl.reg_wr = 1'b1; end
         OPC_SLT: begin ctrl.alu_op = ALU_SLT; ctrl.reg_wr = 1'b1; end
         OPC_LDI: begin
            ctrl.alu_op  = ALU_PASSB;
            ctrl.use_imm = 1'b1;
            ctrl.reg_wr  = 1'b1;
         end
         OPC_ADI: begin
            ctrl.alu_op  = ALU_ADD;
            ctrl.use_imm = 1'b1;
            ctrl.reg_wr  = 1'b1;
         end
         OPC_BEZ: begin
            ctrl.branch     = 1'b1;
            ctrl.br_on_zero = 1'b1;
            ctrl.test_rd    = 1'b1;
         end
         OPC_BNZ: begin
            ctrl.branch  = 1'b1;
            ctrl.test_rd = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int DW = 4
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  alu_op_e       op,
   output logic [DW-1:0] y
);
   always_comb begin
      case (op)
         ALU_ADD:   y = a + b;
         ALU_SUB:   y = a - b;
         ALU_AND:   y = a & b;
         ALU_OR:    y = a | b;
         ALU_SLT:   y = (a < b) ? DW'(1) : '0;
         ALU_PASSB: y = b;
         default:   y = '0;
      endcase
   end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
   import sc_pkg::*;
#(
   parameter int DW   = 4,
   parameter int NREG = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [FIELD_W-1:0] ra_sel,
   input  logic [FIELD_W-1:0] rb_sel,
   input  logic               we,
   input  logic [FIELD_W-1:0] wa_sel,
   input  logic [DW-1:0]      wd,
   output logic [DW-1:0]      ra_data,
   output logic [DW-1:0]      rb_data,
   output logic [NREG*DW-1:0] dbg_flat
);
   localparam int RIDX_W = $clog2(NREG);

   logic [RIDX_W-1:0] ra_idx, rb_idx, wa_idx;
   logic [DW-1:0]     regs [NREG];

   assign ra_idx = ra_sel[RIDX_W-1:0];
   assign rb_idx = rb_sel[RIDX_W-1:0];
   assign wa_idx = wa_sel[RIDX_W-1:0];

   generate
      if (RIDX_W < FIELD_W) begin : g_spare_bits
         logic unused_hi;
         assign unused_hi = ^{ra_sel[FIELD_W-1:RIDX_W],
                              rb_sel[FIELD_W-1:RIDX_W],
                              wa_sel[FIELD_W-1:RIDX_W]};
      end
      for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst)
               regs[gi] <= '0;
            else if (we && wa_idx == RIDX_W'(gi))
               regs[gi] <= wd;
         end
         assign dbg_flat[gi*DW +: DW] = regs[gi];
      end
   endgenerate

   assign ra_data = regs[ra_idx];
   assign rb_data = regs[rb_idx];
endmodule

// File: rtl/sc_imem.sv
module sc_imem
   import sc_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic               clk,
   input  logic               we,
   input  logic [AW-1:0]      waddr,
   input  logic [INSTR_W-1:0] wdata,
   input  logic [AW-1:0]      raddr,
   output logic [INSTR_W-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [INSTR_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter int DW   = 4,
   parameter int AW   = 4,
   parameter int NREG = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               imem_we,
   input  logic [AW-1:0]      imem_waddr,
   input  logic [15:0]        imem_wdata,
   output logic [NREG*DW-1:0] dbg_regs,
   output logic [DW-1:0]      dbg_alu
);
   localparam int RIDX_W = $clog2(NREG);

   generate
      if (DW < FIELD_W) begin : g_bad_dw
         $error("sc_core: DW must be at least the immediate width");
      end
      if (NREG < 2 || (1 << RIDX_W) != NREG || RIDX_W > FIELD_W) begin : g_bad_nreg
         $error("sc_core: NREG must be a power of two between 2 and 16");
      end
      if (AW < 1 || AW > 12) begin : g_bad_aw
         $error("sc_core: AW out of range");
      end
   endgenerate

   logic [AW-1:0]      pc_q;
   logic [INSTR_W-1:0] instr;
   ctrl_t              ctrl;
   logic [FIELD_W-1:0] f_op, f_rd, f_rs1, f_lo;
   logic [DW-1:0]      ra_data, rb_data, opb, alu_y;
   logic               rf_we, br_taken, ra_zero;

   sc_imem #(.AW(AW)) u_imem (
      .clk   (clk),
      .we    (imem_we),
      .waddr (imem_waddr),
      .wdata (imem_wdata),
      .raddr (pc_q),
      .rdata (instr)
   );

   assign f_op  = instr[15:12];
   assign f_rd  = instr[11:8];
   assign f_rs1 = instr[7:4];
   assign f_lo  = instr[3:0];

   sc_ctrl u_ctrl (
      .opcode (f_op),
      .ctrl   (ctrl)
   );

   assign rf_we = ctrl.reg_wr;

   sc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
      .clk      (clk),
      .rst      (rst),
      .ra_sel   (ctrl.test_rd ? f_rd : f_rs1),
      .rb_sel   (f_lo),
      .we       (rf_we),
      .wa_sel   (f_rd),
      .wd       (alu_y),
      .ra_data  (ra_data),
      .rb_data  (rb_data),
      .dbg_flat (dbg_regs)
   );

   assign opb = ctrl.use_imm ? DW'(f_lo) : rb_data;

   sc_alu #(.DW(DW)) u_alu (
      .a  (ra_data),
      .b  (opb),
      .op (ctrl.alu_op),
      .y  (alu_y)
   );

   assign ra_zero  = (ra_data == '0);
   assign br_taken = ctrl.branch & (ctrl.br_on_zero ? ra_zero : !ra_zero);

   always_ff @(posedge clk) begin
      if (rst)
         pc_q <= '0;
      else if (br_taken)
         pc_q <= pc_q + AW'(f_lo);
      else
         pc_q <= pc_q + AW'(1);
   end

   assign dbg_alu = alu_y;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
   parameter int DW   = 4,
   parameter int AW   = 4,
   parameter int NREG = 4
) (
   input logic               clk,
   input logic               rst,
   input logic [AW-1:0]      pc_q,
   input logic [3:0]         opc,
   input logic [3:0]         imm,
   input logic               rf_we,
   input logic               br_taken,
   input logic [DW-1:0]      alu_y,
   input logic [NREG*DW-1:0] dbg_regs
);
   assert_reset_clear_R1: assert property (@(posedge clk)
      $fell(rst) |-> (pc_q == '0 && dbg_regs == '0));

   assert_slt_bool_R4: assert property (@(posedge clk) disable iff (rst)
      (opc == 4'h4) |-> (alu_y <= DW'(1)));

   assert_branch_target_R7: assert property (@(posedge clk) disable iff (rst)
      br_taken |=> (pc_q == $past(pc_q) + AW'($past(imm))));

   assert_branch_nowrite_R7: assert property (@(posedge clk) disable iff (rst)
      (opc == 4'h8 || opc == 4'h9) |-> !rf_we);

   assert_pc_step_R8: assert property (@(posedge clk) disable iff (rst)
      !br_taken |=> (pc_q == $past(pc_q) + AW'(1)));

   assert_undef_nowrite_R9: assert property (@(posedge clk) disable iff (rst)
      (opc == 4'h5 || opc >= 4'hA) |-> !rf_we);

   assert_regs_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !rf_we |=> $stable(dbg_regs));
endmodule

bind sc_core sc_core_chk #(.DW(DW), .AW(AW), .NREG(NREG)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .pc_q     (pc_q),
   .opc      (instr[15:12]),
   .imm      (instr[3:0]),
   .rf_we    (rf_we),
   .br_taken (br_taken),
   .alu_y    (alu_y),
   .dbg_regs (dbg_regs)
);

// File: tb/sc_core_tb.sv
module sc_core_tb;
   localparam int DW = 4, AW = 4, NREG = 4;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              imem_we = 1'b0;
   logic [AW-1:0]     imem_waddr = '0;
   logic [15:0]       imem_wdata = '0;
   logic [NREG*DW-1:0] dbg_regs;
   logic [DW-1:0]     dbg_alu;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [15:0] prog [16];
   logic [3:0]  mr [4];
   logic [3:0]  mpc;

   always #4 clk = ~clk;

   sc_core #(.DW(DW), .AW(AW), .NREG(NREG)) u_dut (
      .clk(clk), .rst(rst), .imem_we(imem_we), .imem_waddr(imem_waddr),
      .imem_wdata(imem_wdata), .dbg_regs(dbg_regs), .dbg_alu(dbg_alu)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         4'h0, 4'h1, 4'h2, 4'h3: return "R3";
         4'h4:                   return "R4";
         4'h6, 4'h7:             return "R5";
         4'h8, 4'h9:             return "R7";
         default:                return "R9";
      endcase
   endfunction

   function automatic logic [3:0] reg_of(input int i);
      return dbg_regs[i*4 +: 4];
   endfunction

   // reference step of the instruction set (R2 field layout, R6 low-bit select)
   task automatic model_step(input logic [15:0] ins, output bit wr, output logic [3:0] val);
      logic [3:0] op, imm;
      logic [1:0] d, s1, s2;
      op = ins[15:12]; d = ins[9:8]; s1 = ins[5:4]; s2 = ins[1:0]; imm = ins[3:0];
      wr = 1'b1; val = '0;
      case (op)
         4'h0: val = mr[s1] + mr[s2];
         4'h1: val = mr[s1] - mr[s2];
         4'h2: val = mr[s1] & mr[s2];
         4'h3: val = mr[s1] | mr[s2];
         4'h4: val = (mr[s1] < mr[s2]) ? 4'd1 : 4'd0;
         4'h6: val = imm;
         4'h7: val = mr[s1] + imm;
         default: wr = 1'b0;
      endcase
      if (op == 4'h8 && mr[d] == 0)       mpc = mpc + imm;
      else if (op == 4'h9 && mr[d] != 0)  mpc = mpc + imm;
      else                                mpc = mpc + 4'd1;
      if (wr) mr[d] = val;
   endtask

   task automatic run(input string name, input int ncyc);
      bit wr;
      logic [3:0] val;
      logic [15:0] ins;
      rst = 1'b1;
      // R11: load the program while reset is held
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         imem_we = 1'b1; imem_waddr = AW'(i); imem_wdata = prog[i];
      end
      @(negedge clk);
      imem_we = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 4; i++) chk("R1", {name, " reset reg"}, reg_of(i), 0);
      for (int i = 0; i < 4; i++) mr[i] = '0;
      mpc = '0;
      for (int c = 0; c < ncyc; c++) begin
         ins = prog[mpc];
         model_step(ins, wr, val);
         if (wr) chk("R10", {name, " dbg_alu"}, dbg_alu, val);
         @(posedge clk);
         @(negedge clk);
         for (int i = 0; i < 4; i++)
            chk(tag_of(ins[15:12]), {name, " reg after step"}, reg_of(i), mr[i]);
      end
   endtask

   initial begin
      void'($urandom(32'd2024));
      // directed arithmetic program
      for (int i = 0; i < 16; i++) prog[i] = 16'h5000;
      prog[0] = 16'h6103; prog[1] = 16'h6205; prog[2] = 16'h0012;
      prog[3] = 16'h1321; prog[4] = 16'h2012; prog[5] = 16'h4112;
      run("arith", 3);
      chk("R3", "ADD R0", reg_of(0), 8);
      run("arith", 6);
      chk("R3", "AND R0", reg_of(0), 1);
      chk("R3", "SUB R3", reg_of(3), 2);
      chk("R4", "SLT R1", reg_of(1), 1);
      chk("R11", "loaded R2", reg_of(2), 5);

      // branches: taken/untaken for both polarities and PC wrap (R7, R8)
      for (int i = 0; i < 16; i++) prog[i] = 16'hA123;
      prog[0] = 16'h6100; prog[1] = 16'h8103; prog[2] = 16'h6207;
      prog[3] = 16'h6307; prog[4] = 16'h9102; prog[5] = 16'h6009;
      prog[6] = 16'h9003; prog[7] = 16'h6207; prog[8] = 16'h6307;
      prog[9] = 16'h8005; prog[10] = 16'h720F; prog[15] = 16'h9003;
      run("branch", 11);
      chk("R7", "skipped R3", reg_of(3), 0);
      chk("R5", "ADDI wrap R2", reg_of(2), 8);
      run("branch", 13);
      chk("R8", "wrap then LOADI R2", reg_of(2), 7);

      // aliased register fields (R6)
      for (int i = 0; i < 16; i++) prog[i] = 16'hF000;
      prog[0] = 16'h6D0A; prog[1] = 16'h0E59; prog[2] = 16'h4312;
      prog[3] = 16'h1C21;
      run("alias", 4);
      chk("R6", "R1 via field D", reg_of(1), 10);
      chk("R6", "R2 via field E", reg_of(2), 4);
      chk("R4", "SLT false R3", reg_of(3), 0);
      chk("R3", "SUB wrap R0", reg_of(0), 10);

      // random programs
      for (int p = 0; p < 10; p++) begin
         for (int i = 0; i < 16; i++) prog[i] = 16'($urandom);
         for (int i = 0; i < 4; i++) prog[i] = {4'h6, 4'(i), 4'h0, 4'($urandom)};
         run("random", 40);
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule